// File: doc/BRIEF.md
# ASID-Tagged Fully Associative Translation Cache

This block converts a 32-bit virtual address into a physical address for one requester. It holds a parameterised number of translations (64 by default). Any translation may sit in any slot. Each slot is tagged with a 6-bit address-space number, so translations from many processes can stay resident at once and a process switch needs no flush. A slot can also be marked global, which makes it match every address-space number.

The top three address bits pick a fixed segment. The user half and the top kernel quarter are translated. The two remaining kernel eighths bypass the cache and are mapped directly onto physical memory, one cached and one uncached.

A lookup is answered one cycle later with one of three results: a hit carrying the frame and access rights, a miss telling an external refill agent to supply the entry, or a protection fault for a store to a read-only page. The refill agent installs entries through a write port. Software removes stale entries through an invalidate port whenever a page-table entry changes.

Top module: `asid_tlb`

## Requirements
- R1: Segment decode works as follows:
  - Addresses with bit 31 = 0, or with bits 31:30 = 11, are translated.
  - Bits 31:29 = 100 select the direct cached segment and 101 the direct uncached segment.
  - A direct lookup always hits and is writable. Its physical address is the virtual address with bits 31:29 cleared, and `rsp_cached` is 1 for 100 and 0 for 101.
- R2: Every lookup accepted with `lk_valid` high produces exactly one response, with `rsp_valid` high in the following cycle.
  - Within a response, exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is high.
  - When `rsp_valid` is low, all response outputs are 0.
- R3: A translated lookup matches a valid entry only when the entry's page number equals address bits 31:12 and its ASID equals `lk_asid`. On a hit, `rsp_paddr` is {frame, address bits 11:0} and `rsp_cached` is 1.
- R4: An entry installed with the global flag set matches the same page under any ASID.
- R5: A translated lookup that matches no valid entry returns `rsp_miss`.
- R6: A store (`lk_store`=1) that matches an entry whose writable flag is 0 returns `rsp_fault` with `rsp_hit` low. A load that matches the same entry hits.
- R7: The invalidate port clears every valid entry whose page equals `inv_vpn` and whose ASID equals `inv_asid` or which is global. Entries with another page, or with another ASID and not global, are untouched.
- R8: Writing a page/ASID key that an entry already holds overwrites that entry in place, so no duplicate is made.
- R9: When no entry holds the key, a write fills the lowest-numbered invalid slot and leaves the replacement pointer unchanged.
- R10: When every slot is valid and no entry holds the key, the write replaces the slot named by the replacement pointer. The pointer then advances by one, wrapping from the last slot to 0.
- R11: Reset leaves every slot invalid, the replacement pointer at 0 and `rsp_valid` low.
- R12: When an invalidate and a write arrive in the same cycle, the invalidate is applied first and the write is installed after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 6 | Address-space number of the requester |
| lk_store | input | 1 | 1 for a store, 0 for a load |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation available |
| rsp_miss | output | 1 | No entry; refill needed |
| rsp_fault | output | 1 | Store to a read-only page |
| rsp_paddr | output | 32 | Physical address (valid with `rsp_hit`) |
| rsp_writable | output | 1 | Page may be written |
| rsp_cached | output | 1 | Access may be cached |
| wr_en | input | 1 | Install an entry |
| wr_vpn | input | 20 | Page number of the new entry |
| wr_asid | input | 6 | ASID of the new entry |
| wr_pfn | input | 20 | Physical frame of the new entry |
| wr_writable | input | 1 | Writable flag of the new entry |
| wr_global | input | 1 | Global flag of the new entry |
| inv_en | input | 1 | Invalidate request |
| inv_vpn | input | 20 | Page number to invalidate |
| inv_asid | input | 6 | ASID to invalidate |

## Verification
Each lookup result appears one cycle after the edge that accepts the request, because only the response register sits between the ports. A write or an invalidate takes effect at its own edge, so a lookup issued in the next cycle already sees it. The bench drives every request on a falling edge. It reads the response on the falling edge one cycle later, halfway between the edge that registers the result and the following edge. Replacement order can only be seen through later lookups, so each eviction is checked by probing the evicted page and its neighbours.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
    localparam int VA_W   = 32;
    localparam int OFS_W  = 12;
    localparam int VPN_W  = VA_W - OFS_W;
    localparam int PFN_W  = 20;
    localparam int PA_W   = PFN_W + OFS_W;
    localparam int ASID_W = 6;
    localparam int SEG_W  = 3;

    typedef enum logic [1:0] {
        SEG_USER      = 2'd0,
        SEG_DIRECT_C  = 2'd1,
        SEG_DIRECT_U  = 2'd2,
        SEG_KMAPPED   = 2'd3
    } seg_e;

    typedef struct packed {
        logic              valid;
        logic              writable;
        logic              glb;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
    } entry_t;

    typedef struct packed {
        logic            valid;
        logic            hit;
        logic            miss;
        logic            fault;
        logic            writable;
        logic            cached;
        logic [PA_W-1:0] paddr;
    } rsp_t;
endpackage

// File: rtl/tlb_seg_decode.sv
module tlb_seg_decode
    import asid_tlb_pkg::*;
(
    input  logic [VA_W-1:0] vaddr,
    output seg_e            seg,
    output logic            mapped,
    output logic            cached,
    output logic [PA_W-1:0] direct_pa
);
    always_comb begin
        if (!vaddr[VA_W-1])      seg = SEG_USER;
        else if (vaddr[VA_W-2])  seg = SEG_KMAPPED;
        else if (vaddr[VA_W-3])  seg = SEG_DIRECT_U;
        else                     seg = SEG_DIRECT_C;
        mapped    = (seg == SEG_USER) || (seg == SEG_KMAPPED);
        cached    = (seg != SEG_DIRECT_U);
        direct_pa = {{SEG_W{1'b0}}, vaddr[VA_W-SEG_W-1:0]};
    end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
    import asid_tlb_pkg::*;
#(
    parameter  int ENTRIES = 64,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [ASID_W-1:0]  lk_asid,
    output logic               lk_hit,
    output entry_t             lk_entry,
    input  logic               inv_en,
    input  logic [VPN_W-1:0]   inv_vpn,
    input  logic [ASID_W-1:0]  inv_asid,
    input  logic               wr_en,
    input  entry_t             wr_key,
    input  logic [IDX_W-1:0]   wr_idx,
    output logic [ENTRIES-1:0] live_vec,
    output logic [ENTRIES-1:0] wr_match_vec
);
    typedef struct packed {
        entry_t [ENTRIES-1:0] ent;
    } cam_state_t;

    cam_state_t st_d, st_q;

    // Next state: invalidate first, then the write lands on top of it.
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if (inv_en && st_q.ent[i].valid && st_q.ent[i].vpn == inv_vpn &&
                (st_q.ent[i].asid == inv_asid || st_q.ent[i].glb))
                st_d.ent[i].valid = 1'b0;
            live_vec[i]     = st_d.ent[i].valid;
            wr_match_vec[i] = st_d.ent[i].valid && st_d.ent[i].vpn == wr_key.vpn &&
                              (st_d.ent[i].asid == wr_key.asid || st_d.ent[i].glb || wr_key.glb);
        end
        if (wr_en)
            st_d.ent[wr_idx] = wr_key;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Associative search on the registered array; the lowest slot wins.
    always_comb begin
        lk_hit   = 1'b0;
        lk_entry = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (st_q.ent[i].valid && st_q.ent[i].vpn == lk_vpn &&
                (st_q.ent[i].glb || st_q.ent[i].asid == lk_asid)) begin
                lk_hit   = 1'b1;
                lk_entry = st_q.ent[i];
            end
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter  int ENTRIES = 64,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ENTRIES-1:0] live_vec,
    input  logic [ENTRIES-1:0] match_vec,
    output logic [IDX_W-1:0]   wr_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [IDX_W-1:0] ptr;
    } vic_state_t;

    vic_state_t st_d, st_q;
    logic             match_found, free_found;
    logic [IDX_W-1:0] match_idx, free_idx;

    always_comb begin
        match_found = 1'b0;
        free_found  = 1'b0;
        match_idx   = '0;
        free_idx    = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                match_found = 1'b1;
                match_idx   = IDX_W'(i);
            end
            if (!live_vec[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (match_found)     wr_idx = match_idx;
        else if (free_found) wr_idx = free_idx;
        else                 wr_idx = st_q.ptr;
        if (wr_en && !match_found && !free_found)
            st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import asid_tlb_pkg::*;
#(
    parameter  int ENTRIES = 64,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_store,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_writable,
    output logic              rsp_cached,
    input  logic              wr_en,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic              wr_writable,
    input  logic              wr_global,
    input  logic              inv_en,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic [ASID_W-1:0] inv_asid
);
    seg_e               seg;
    logic               seg_mapped, seg_cached;
    logic [PA_W-1:0]    direct_pa;
    logic               cam_hit;
    entry_t             cam_entry, wr_key;
    logic [ENTRIES-1:0] live_vec, match_vec;
    logic [IDX_W-1:0]   wr_idx;
    rsp_t               rsp_d, rsp_q;

    tlb_seg_decode u_seg (
        .vaddr     (lk_vaddr),
        .seg       (seg),
        .mapped    (seg_mapped),
        .cached    (seg_cached),
        .direct_pa (direct_pa)
    );

    always_comb begin
        wr_key          = '0;
        wr_key.valid    = 1'b1;
        wr_key.writable = wr_writable;
        wr_key.glb      = wr_global;
        wr_key.asid     = wr_asid;
        wr_key.vpn      = wr_vpn;
        wr_key.pfn      = wr_pfn;
    end

    tlb_cam #(.ENTRIES(ENTRIES)) u_cam (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_vpn       (lk_vaddr[VA_W-1:OFS_W]),
        .lk_asid      (lk_asid),
        .lk_hit       (cam_hit),
        .lk_entry     (cam_entry),
        .inv_en       (inv_en),
        .inv_vpn      (inv_vpn),
        .inv_asid     (inv_asid),
        .wr_en        (wr_en),
        .wr_key       (wr_key),
        .wr_idx       (wr_idx),
        .live_vec     (live_vec),
        .wr_match_vec (match_vec)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .live_vec  (live_vec),
        .match_vec (match_vec),
        .wr_idx    (wr_idx)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = lk_valid;
        if (lk_valid) begin
            if (!seg_mapped) begin
                rsp_d.hit      = 1'b1;
                rsp_d.writable = 1'b1;
                rsp_d.cached   = seg_cached;
                rsp_d.paddr    = direct_pa;
            end else if (!cam_hit) begin
                rsp_d.miss = 1'b1;
            end else if (lk_store && !cam_entry.writable) begin
                rsp_d.fault = 1'b1;
            end else begin
                rsp_d.hit      = 1'b1;
                rsp_d.writable = cam_entry.writable;
                rsp_d.cached   = 1'b1;
                rsp_d.paddr    = {cam_entry.pfn, lk_vaddr[OFS_W-1:0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid    = rsp_q.valid;
    assign rsp_hit      = rsp_q.hit;
    assign rsp_miss     = rsp_q.miss;
    assign rsp_fault    = rsp_q.fault;
    assign rsp_paddr    = rsp_q.paddr;
    assign rsp_writable = rsp_q.writable;
    assign rsp_cached   = rsp_q.cached;
endmodule

// File: rtl/asid_tlb_checks.sv
module asid_tlb_checks
    import asid_tlb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [VA_W-1:0]   lk_vaddr,
    input logic [ASID_W-1:0] lk_asid,
    input logic              lk_store,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_miss,
    input logic              rsp_fault,
    input logic [PA_W-1:0]   rsp_paddr,
    input logic              rsp_cached,
    input logic              wr_en,
    input logic              inv_en,
    input logic [VPN_W-1:0]  inv_vpn,
    input logic [ASID_W-1:0] inv_asid
);
    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    assert_one_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

    assert_quiet_outputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_paddr == '0 && !rsp_hit && !rsp_miss && !rsp_fault));

    assert_direct_map_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_vaddr[VA_W-1 -: 2] == 2'b10) |=>
        (rsp_hit && rsp_paddr == {{SEG_W{1'b0}}, $past(lk_vaddr[VA_W-SEG_W-1:0])}));

    assert_uncached_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_vaddr[VA_W-1 -: SEG_W] == 3'b101) |=> !rsp_cached);

    assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_paddr[OFS_W-1:0] == $past(lk_vaddr[OFS_W-1:0]));

    assert_fault_on_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> $past(lk_store));

    assert_inv_then_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && !wr_en) ##1
        (lk_valid && lk_vaddr[VA_W-1 -: 2] != 2'b10 &&
         lk_vaddr[VA_W-1:OFS_W] == $past(inv_vpn) && lk_asid == $past(inv_asid))
        |=> !rsp_hit);
endmodule

bind asid_tlb asid_tlb_checks u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_vaddr   (lk_vaddr),
    .lk_asid    (lk_asid),
    .lk_store   (lk_store),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_miss   (rsp_miss),
    .rsp_fault  (rsp_fault),
    .rsp_paddr  (rsp_paddr),
    .rsp_cached (rsp_cached),
    .wr_en      (wr_en),
    .inv_en     (inv_en),
    .inv_vpn    (inv_vpn),
    .inv_asid   (inv_asid)
);

// File: tb/asid_tlb_bench.sv
`timescale 1ns/1ps
module asid_tlb_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [5:0]  lk_asid = '0;
    logic        lk_store = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_writable, rsp_cached;
    logic [31:0] rsp_paddr;
    logic        wr_en = 1'b0;
    logic [19:0] wr_vpn = '0;
    logic [5:0]  wr_asid = '0;
    logic [19:0] wr_pfn = '0;
    logic        wr_writable = 1'b0;
    logic        wr_global = 1'b0;
    logic        inv_en = 1'b0;
    logic [19:0] inv_vpn = '0;
    logic [5:0]  inv_asid = '0;

    int checks = 0;
    int failures = 0;
    logic r_valid, r_hit, r_miss, r_fault, r_cached;
    logic [31:0] r_paddr;

    always #2 clk = ~clk;

    asid_tlb u_asid_tlb (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_store(lk_store),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .rsp_writable(rsp_writable), .rsp_cached(rsp_cached),
        .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_pfn(wr_pfn),
        .wr_writable(wr_writable), .wr_global(wr_global),
        .inv_en(inv_en), .inv_vpn(inv_vpn), .inv_asid(inv_asid)
    );

    typedef struct packed {
        logic [31:0] va;
        logic [5:0]  asid;
        logic        st;
        logic        hit;
        logic        miss;
        logic        fault;
        logic        cached;
        logic [31:0] pa;
    } vec_t;

    // Installed before the walk: page 0x00012/asid 5 rw, page 0x00034/asid 5 ro,
    // page 0xC0000 global rw.
    localparam vec_t VEC [0:7] = '{
        '{32'h0001_2345, 6'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'hABCD_E345}, // R3
        '{32'h0001_2345, 6'd6, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0},         // R3 R5
        '{32'h0003_4010, 6'd5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0},         // R6
        '{32'h0003_4010, 6'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h1111_1010}, // R6
        '{32'hC000_0ABC, 6'd9, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h2222_2ABC}, // R4
        '{32'h8000_1234, 6'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_1234}, // R1
        '{32'hA765_4321, 6'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0765_4321}, // R1
        '{32'h7FFF_F000, 6'd5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0}          // R5
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [19:0] vpn, input logic [5:0] asid,
                            input logic [19:0] pfn, input logic w, input logic g);
        @(negedge clk);
        wr_en = 1'b1; wr_vpn = vpn; wr_asid = asid; wr_pfn = pfn;
        wr_writable = w; wr_global = g;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_inv(input logic [19:0] vpn, input logic [5:0] asid, input logic with_wr,
                          input logic [19:0] pfn);
        @(negedge clk);
        inv_en = 1'b1; inv_vpn = vpn; inv_asid = asid;
        wr_en = with_wr; wr_vpn = vpn; wr_asid = asid; wr_pfn = pfn;
        wr_writable = 1'b1; wr_global = 1'b0;
        @(negedge clk);
        inv_en = 1'b0; wr_en = 1'b0;
    endtask

    // Request on a falling edge; result registered at the next rising edge,
    // read on the falling edge after it.
    task automatic do_lookup(input logic [31:0] va, input logic [5:0] asid, input logic st);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_asid = asid; lk_store = st;
        @(negedge clk);
        lk_valid = 1'b0; lk_store = 1'b0;
        r_valid = rsp_valid; r_hit = rsp_hit; r_miss = rsp_miss;
        r_fault = rsp_fault; r_cached = rsp_cached; r_paddr = rsp_paddr;
    endtask

    task automatic expect_hit(input string req, input logic [31:0] pa);
        check(r_valid && r_hit && !r_miss && !r_fault, req, "hit flags",
              {28'h0, r_valid, r_hit, r_miss, r_fault}, 32'hC);
        check(r_paddr == pa, req, "paddr", r_paddr, pa);
    endtask

    task automatic expect_miss(input string req);
        check(r_valid && r_miss && !r_hit && !r_fault, req, "miss flags",
              {28'h0, r_valid, r_hit, r_miss, r_fault}, 32'hA);
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        // R11: reset state
        @(negedge clk);
        check(rsp_valid == 1'b0, "R11", "rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
        do_lookup(32'h0000_1000, 6'd0, 1'b0);
        expect_miss("R11");
        // R2: no response without a request
        @(negedge clk);
        check(rsp_valid == 1'b0, "R2", "idle rsp_valid", {31'h0, rsp_valid}, 32'h0);

        do_write(20'h00012, 6'd5, 20'hABCDE, 1'b1, 1'b0);
        do_write(20'h00034, 6'd5, 20'h11111, 1'b0, 1'b0);
        do_write(20'hC0000, 6'd2, 20'h22222, 1'b1, 1'b1);

        for (int i = 0; i < 8; i++) begin
            do_lookup(VEC[i].va, VEC[i].asid, VEC[i].st);
            check(r_valid == 1'b1, "R2", $sformatf("vector %0d valid", i), {31'h0, r_valid}, 32'h1);
            check({r_hit, r_miss, r_fault} == {VEC[i].hit, VEC[i].miss, VEC[i].fault},
                  "R1/R3/R4/R5/R6", $sformatf("vector %0d result", i),
                  {29'h0, r_hit, r_miss, r_fault}, {29'h0, VEC[i].hit, VEC[i].miss, VEC[i].fault});
            if (VEC[i].hit) begin
                check(r_paddr == VEC[i].pa, "R1/R3/R4", $sformatf("vector %0d paddr", i), r_paddr, VEC[i].pa);
                check(r_cached == VEC[i].cached, "R1", $sformatf("vector %0d cached", i),
                      {31'h0, r_cached}, {31'h0, VEC[i].cached});
            end
        end

        // R8: rewrite an existing key with a new frame and write permission
        do_write(20'h00034, 6'd5, 20'h33333, 1'b1, 1'b0);
        do_lookup(32'h0003_4010, 6'd5, 1'b1);
        expect_hit("R8", 32'h3333_3010);

        // R7: other ASID leaves entry; matching ASID removes it; global removed by any ASID
        do_inv(20'h00034, 6'd7, 1'b0, 20'h0);
        do_lookup(32'h0003_4010, 6'd5, 1'b0);
        expect_hit("R7", 32'h3333_3010);
        do_inv(20'h00012, 6'd5, 1'b0, 20'h0);
        do_lookup(32'h0001_2345, 6'd5, 1'b0);
        expect_miss("R7");
        do_inv(20'hC0000, 6'd3, 1'b0, 20'h0);
        do_lookup(32'hC000_0ABC, 6'd2, 1'b0);
        expect_miss("R7");

        // R12: invalidate and write in the same cycle
        do_write(20'h00055, 6'd5, 20'h0AAAA, 1'b1, 1'b0);
        do_inv(20'h00055, 6'd5, 1'b1, 20'h44444);
        do_lookup(32'h0005_5008, 6'd5, 1'b0);
        expect_hit("R12", 32'h4444_4008);

        // R9 / R10: replacement order from a clean state
        do_reset();
        for (int i = 0; i < 64; i++)
            do_write(20'(i), 6'd1, 20'(32'h100 + i), 1'b1, 1'b0);
        do_lookup(32'h0003_F000, 6'd1, 1'b0);
        expect_hit("R9", 32'h0013_F000);
        do_write(20'd200, 6'd1, 20'h00999, 1'b1, 1'b0);
        do_lookup(32'h0000_0000, 6'd1, 1'b0);
        expect_miss("R10");
        do_lookup(32'h0000_1000, 6'd1, 1'b0);
        expect_hit("R10", 32'h0010_1000);
        do_lookup(32'h000C_8000, 6'd1, 1'b0);
        expect_hit("R10", 32'h0099_9000);
        do_inv(20'd10, 6'd1, 1'b0, 20'h0);
        do_write(20'd201, 6'd1, 20'h00AAA, 1'b1, 1'b0);
        do_lookup(32'h0000_1000, 6'd1, 1'b0);
        expect_hit("R9", 32'h0010_1000);
        do_lookup(32'h000C_9000, 6'd1, 1'b0);
        expect_hit("R9", 32'h00AA_A000);
        do_write(20'd202, 6'd1, 20'h00BBB, 1'b1, 1'b0);
        do_lookup(32'h0000_1000, 6'd1, 1'b0);
        expect_miss("R10");
        do_lookup(32'h0000_2000, 6'd1, 1'b0);
        expect_hit("R10", 32'h0010_2000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule